// File: doc/BRIEF.md
# Strobe-Paced Read Port

This block sits on the device side of a parallel host bus that has no address lines. The host reads it like a FIFO. Each read is an active-low chip select plus a falling edge of an active-low output-enable strobe. Every qualified strobe hands the host the next word. The word comes either from a built-in counting pattern or from the head of an external show-ahead FIFO, chosen by a static mode pin. A separate active-low rewind line returns the pattern to its start, so that a host can re-run a known sequence and check it.

All three host controls are asynchronous to the local clock. They pass through two-flop synchronizers. A four-state machine then paces the reads. In **IDLE** chip select is high. In **ARMED** the block is selected and the strobe is high. **FETCH** lasts one cycle, in which the word is advanced. In **DRIVE** the block owns the bus.

The transitions are:
- IDLE→ARMED when select is low and the strobe is high.
- ARMED→IDLE when select rises.
- ARMED→FETCH when the strobe falls.
- FETCH→DRIVE when both controls are still low.
- FETCH or DRIVE → ARMED when the strobe rises.
- FETCH or DRIVE → IDLE when select rises.

The bus pad is driven from `bus_dout` and gated by `bus_drive`.

Top module: `strobe_read_port`

## Requirements
- R1: After `rst_n` is released, `bus_drive`, `fifo_pop` and `underflow` are 0 until the host issues a qualified read.
- R2: Each falling edge of `host_oe_n` while `host_cs_n` is low advances the word exactly once. In pattern mode (`fifo_mode`=0), the n-th read after reset or rewind returns n. Between reads the presented word does not change.
- R3: `bus_drive` is 1 only while both synchronized controls are low. It rises at the fourth rising clock edge after the strobe falls, not before the third. It drops by the third edge after either control rises. While it is 1, `bus_dout` is stable.
- R4: Holding `host_rdrst_n` low clears the pattern pointer and `underflow`. The first read after the line returns high yields 1.
- R5: The pattern wraps from all ones (0xFFFF at the default width) to zero.
- R6: In FIFO mode (`fifo_mode`=1), each read whose FIFO is not empty pulses `fifo_pop` for exactly one cycle and presents the FIFO head word.
- R7: A FIFO-mode read while `fifo_empty`=1 issues no pop and keeps the previous word. It sets `underflow`, which stays 1 through later reads until a rewind or a reset.
- R8: A strobe fall while `host_cs_n` is high is ignored. It does not drive the bus and does not advance the word.
- R9: Back-to-back reads with a host period of about 57.6 ns return a 4096-word run with no skipped or repeated word, provided the local clock is at least four times the strobe rate.
- R10: Select falling while the strobe is already low is not a read. The machine waits in IDLE until it sees the strobe high, so the bus stays released and the next proper strobe returns the next word without a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 0: counting pattern, 1: external FIFO source |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_oe_n | input | 1 | Host read strobe, active low, asynchronous |
| host_rdrst_n | input | 1 | Rewind of the read pointer, active low, asynchronous |
| fifo_rd_data | input | DATA_W | Head word of the external show-ahead FIFO |
| fifo_empty | input | 1 | External FIFO has no word |
| fifo_pop | output | 1 | One-cycle pop request to the external FIFO |
| bus_dout | output | DATA_W | Word presented to the host bus pad |
| bus_drive | output | 1 | Output enable of the bus pad (1 = drive, 0 = high impedance) |
| underflow | output | 1 | Sticky flag: a read found the FIFO empty |

## Verification
A pointer that slips or double-steps shows up on the very next read. The returned word is then off by one from the arithmetic count, and every later word stays off until a rewind. The long sweep therefore pins the first faulty read exactly. A state machine stuck in the wrong state shows within a few local cycles of the strobe. It either drives the bus while the host is deselected or fails to drive it by the sixth cycle of a read. FIFO-side faults appear as a pop count that differs from the number of non-empty reads, or as an underflow flag that drops before a rewind.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;
    typedef enum logic [1:0] {
        SRP_IDLE  = 2'd0,
        SRP_ARMED = 2'd1,
        SRP_FETCH = 2'd2,
        SRP_DRIVE = 2'd3
    } srp_state_t;
endpackage

// File: rtl/srp_sync.sv
`timescale 1ns/1ps
module srp_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g]   <= RST_VAL[g];
                sync_out[g] <= RST_VAL[g];
            end else begin
                meta_q[g]   <= async_in[g];
                sync_out[g] <= meta_q[g];
            end
        end
    end
endmodule

// File: rtl/srp_fsm.sv
`timescale 1ns/1ps
module srp_fsm
    import srp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic oe_s,
    output logic advance,
    output logic drive
);
    srp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRP_IDLE: begin
                if (!cs_s && oe_s) state_d = SRP_ARMED;
            end
            SRP_ARMED: begin
                if (cs_s)       state_d = SRP_IDLE;
                else if (!oe_s) state_d = SRP_FETCH;
            end
            SRP_FETCH, SRP_DRIVE: begin
                if (cs_s)      state_d = SRP_IDLE;
                else if (oe_s) state_d = SRP_ARMED;
                else           state_d = SRP_DRIVE;
            end
            default: state_d = SRP_IDLE;
        endcase
    end

    always_comb begin
        advance = 1'b0;
        drive   = 1'b0;
        unique case (state_q)
            SRP_FETCH: advance = 1'b1;
            SRP_DRIVE: drive   = 1'b1;
            default: ;
        endcase
    end

    AST_ADVANCE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> !advance); // R2

    AST_DRIVE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> $past(!cs_s && !oe_s)); // R3

    AST_NO_READ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !advance) |=> !advance); // R8
endmodule

// File: rtl/srp_source.sv
`timescale 1ns/1ps
module srp_source #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              advance,
    input  logic              ptr_clr,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              pop,
    output logic [DATA_W-1:0] word,
    output logic              underflow
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(1);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + STEP;
    assign pop     = advance && fifo_mode && !fifo_empty && !ptr_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            word      <= '0;
            underflow <= 1'b0;
        end else if (ptr_clr) begin
            cnt_q     <= '0;
            underflow <= 1'b0;
        end else if (advance) begin
            if (fifo_mode) begin
                if (fifo_empty) underflow <= 1'b1;
                else            word      <= fifo_data;
            end else begin
                cnt_q <= cnt_inc;
                word  <= cnt_inc;
            end
        end
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (cnt_q == '0 && !underflow)); // R4

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !ptr_clr) |=> underflow); // R7

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(word)); // R2

    AST_NO_POP_EMPTY_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !$past(pop)) |-> ##0 (!pop || !fifo_empty)); // R7
endmodule

// File: rtl/strobe_read_port.sv
`timescale 1ns/1ps
module strobe_read_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              host_cs_n,
    input  logic              host_oe_n,
    input  logic              host_rdrst_n,
    input  logic [DATA_W-1:0] fifo_rd_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_drive,
    output logic              underflow
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] ctl_s;
    logic             cs_s, oe_s, rr_s;
    logic             advance;

    srp_sync #(.WIDTH(NSYNC), .RST_VAL('1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_rdrst_n, host_oe_n, host_cs_n}),
        .sync_out (ctl_s)
    );

    assign cs_s = ctl_s[0];
    assign oe_s = ctl_s[1];
    assign rr_s = ctl_s[2];

    srp_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .oe_s    (oe_s),
        .advance (advance),
        .drive   (bus_drive)
    );

    srp_source #(.DATA_W(DATA_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .advance    (advance),
        .ptr_clr    (!rr_s),
        .fifo_data  (fifo_rd_data),
        .fifo_empty (fifo_empty),
        .pop        (fifo_pop),
        .word       (bus_dout),
        .underflow  (underflow)
    );

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive && $past(bus_drive)) |-> $stable(bus_dout)); // R3

    AST_POP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop); // R6
endmodule

// File: tb/sim_strobe_read_port.sv
`timescale 1ns/1ps
module sim_strobe_read_port;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_mode = 1'b0;
    logic          cs_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          rr_n = 1'b1;
    logic [DW-1:0] fifo_rd_data;
    logic          fifo_empty;
    logic          fifo_pop;
    logic [DW-1:0] bus_dout;
    logic          bus_drive;
    logic          underflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] fq [16];
    int head = 0;
    int tail = 0;
    int pops = 0;

    always #2 clk = ~clk;

    assign fifo_rd_data = fq[head % 16];
    assign fifo_empty   = (head == tail);

    always @(posedge clk) begin
        if (fifo_pop) begin
            head <= head + 1;
            pops <= pops + 1;
        end
    end

    strobe_read_port #(.DATA_W(DW)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_mode    (fifo_mode),
        .host_cs_n    (cs_n),
        .host_oe_n    (oe_n),
        .host_rdrst_n (rr_n),
        .fifo_rd_data (fifo_rd_data),
        .fifo_empty   (fifo_empty),
        .fifo_pop     (fifo_pop),
        .bus_dout     (bus_dout),
        .bus_drive    (bus_drive),
        .underflow    (underflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_read(output logic [DW-1:0] d, output logic drv, output logic early);
        oe_n = 1'b0;
        wait_neg(3);
        early = bus_drive;
        wait_neg(3);
        d   = bus_dout;
        drv = bus_drive;
        oe_n = 1'b1;
        wait_neg(5);
    endtask

    task automatic rewind();
        rr_n = 1'b0;
        wait_neg(4);
        rr_n = 1'b1;
        wait_neg(4);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic drv, early;
        int exp, p0;

        for (int i = 0; i < 16; i++) fq[i] = DW'(8'hA0 + i * 7);
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(4);
        // R1 reset state
        check(bus_drive == 1'b0, "R1 drive", bus_drive, 0);
        check(fifo_pop == 1'b0, "R1 pop", fifo_pop, 0);
        check(underflow == 1'b0, "R1 underflow", underflow, 0);

        // R2 / R3: counting pattern from 1
        cs_n = 1'b0;
        wait_neg(4);
        for (int n = 1; n <= 10; n++) begin
            host_read(d, drv, early);
            check(d == DW'(n), "R2 pattern word", d, n);
            check(drv == 1'b1, "R3 drive during read", drv, 1);
            check(early == 1'b0, "R3 drive latency", early, 0);
            check(bus_drive == 1'b0, "R3 release after strobe", bus_drive, 0);
        end
        wait_neg(20);
        check(bus_dout == DW'(10), "R2 word held between reads", bus_dout, 10);

        // R8: strobe while deselected
        cs_n = 1'b1;
        wait_neg(4);
        check(bus_drive == 1'b0, "R3 released on deselect", bus_drive, 0);
        oe_n = 1'b0;
        wait_neg(6);
        check(bus_drive == 1'b0, "R8 no drive when deselected", bus_drive, 0);
        oe_n = 1'b1;
        wait_neg(5);
        cs_n = 1'b0;
        wait_neg(4);
        host_read(d, drv, early);
        check(d == DW'(11), "R8 ignored strobe did not advance", d, 11);

        // R10: select falls while strobe already low
        cs_n = 1'b1;
        wait_neg(4);
        oe_n = 1'b0;
        wait_neg(4);
        cs_n = 1'b0;
        wait_neg(8);
        check(bus_drive == 1'b0, "R10 no read without strobe edge", bus_drive, 0);
        oe_n = 1'b1;
        wait_neg(5);
        host_read(d, drv, early);
        check(d == DW'(12), "R10 next word no skip", d, 12);

        // R4: rewind
        rewind();
        host_read(d, drv, early);
        check(d == DW'(1), "R4 first word after rewind", d, 1);
        host_read(d, drv, early);
        check(d == DW'(2), "R4 second word after rewind", d, 2);

        // R9 / R5: 4096-word sweep, wraps every 2**DW words
        rewind();
        for (int n = 1; n <= 4096; n++) begin
            host_read(d, drv, early);
            exp = n % (1 << DW);
            if (exp == 0) check(d == DW'(exp), "R5 wrap to zero", d, exp);
            else          check(d == DW'(exp), "R9 burst sequence", d, exp);
        end

        // R6 / R7: FIFO mode
        fifo_mode = 1'b1;
        rewind();
        tail = head + 5;
        wait_neg(2);
        p0 = pops;
        for (int k = 0; k < 5; k++) begin
            exp = int'(fq[(head) % 16]);
            host_read(d, drv, early);
            check(d == DW'(exp), "R6 fifo head word", d, exp);
            check(pops == p0 + k + 1, "R6 one pop per read", pops, p0 + k + 1);
        end
        check(underflow == 1'b0, "R7 no underflow yet", underflow, 0);
        exp = int'(d);
        host_read(d, drv, early);
        check(d == DW'(exp), "R7 empty read keeps word", d, exp);
        check(pops == p0 + 5, "R7 no pop when empty", pops, p0 + 5);
        check(underflow == 1'b1, "R7 underflow set", underflow, 1);
        tail = head + 1;
        wait_neg(2);
        exp = int'(fq[head % 16]);
        host_read(d, drv, early);
        check(d == DW'(exp), "R6 word after refill", d, exp);
        check(underflow == 1'b1, "R7 underflow sticky", underflow, 1);
        rewind();
        check(underflow == 1'b0, "R7 underflow cleared by rewind", underflow, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule